// File: doc/BRIEF.md
# Exception Frame Push and Pop Sequencer

This block carries out the memory side of exception entry and exception return for a small 32-bit core. When an exception is taken, the core offers a signed exception number, its current stack pointer and a snapshot of eight caller-saved registers. The sequencer waits until the instruction in flight has retired. It then writes the eight-word frame downward onto the stack through a data-memory port. In parallel, it fetches the handler address from the vector table through a separate instruction-side read port. Once both have finished, it hands back the lowered stack pointer, the handler address as the new program counter, and a link-register value that encodes the return path.

On return, the core presents the value held in its link register together with the current stack pointer. If that value is the one supported return code, the sequencer reads the frame back in ascending address order, hands the eight words to the core and raises the stack pointer by the frame size. Any other value is refused with an error pulse and causes no memory traffic. Priority arbitration, chained or late-arriving exceptions, floating-point state and the saving of R4 to R11 belong to other parts of the core.

Top module: `exc_seq`

## Requirements
- R1: An entry request is taken only while `entry_rdy` is 1, which is only when the sequencer is idle. A request made while it is low has no effect. When an entry request and a return request arrive in the same idle cycle, the entry is taken and the return is dropped.
- R2: After an entry is taken, no data-port request is made before `insn_done` is sampled high. The first store is presented in the cycle after that sample.
- R3: `ctx_in` holds word k in bits [32k+31:32k], with k = 0 R0, 1 R1, 2 R2, 3 R3, 4 R12, 5 LR, 6 PC, 7 PSR. Entry performs exactly eight word-aligned stores, in the order PSR, PC, LR, R12, R3, R2, R1, R0, to addresses SP-4, SP-8, ... down to SP-32.
- R4: A data-port transfer completes in a cycle where both `dm_valid` and `dm_ready` are 1. While `dm_ready` is 0, the address, the write flag and the write data are held.
- R5: The vector address is VT_BASE + 64 + 4n, where n is `entry_num` read as a two's-complement number (for example, n = 2 gives 0x48 and n = -11 gives 0x14). `im_valid` is raised in the same cycle as the first store, and the address is held while `im_ready` is 0.
- R6: Entry finishes with a one-cycle `entry_done` pulse once both the eight stores and the vector read are complete. At that point `sp_out` = SP-32, `pc_out` = the fetched word, `lr_out` = 0xFFFFFFF9 and `handler_mode` = 1.
- R7: A return request with code 0xFFFFFFF9 reads eight words from SP, SP+4, ... up to SP+28, in that order (R0 first, PSR last). It ends with a one-cycle `ret_done` pulse, with `ctx_out` holding the words read (same layout as `ctx_in`), `sp_out` = SP+32 and `handler_mode` = 0.
- R8: A return request with any other code makes no memory access. It raises `ret_err` for exactly the following cycle and leaves `handler_mode`, `sp_out` and `ctx_out` unchanged.
- R9: After reset, `entry_rdy` = 1, all request and pulse outputs are 0, `handler_mode` = 0, and `sp_out`, `pc_out`, `lr_out` and `ctx_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | Exception accepted by the core, take entry |
| entry_num | input | NUM_W | Signed exception number |
| entry_rdy | output | 1 | Sequencer idle, requests are taken |
| insn_done | input | 1 | Instruction in flight has retired |
| ctx_in | input | 256 | Eight registers to be pushed |
| sp_in | input | 32 | Current stack pointer |
| ret_req | input | 1 | Exception return request |
| ret_code | input | 32 | Link-register value given on return |
| dm_valid | output | 1 | Data-port request |
| dm_write | output | 1 | Data-port request is a store |
| dm_addr | output | 32 | Data-port byte address |
| dm_wdata | output | 32 | Store data |
| dm_ready | input | 1 | Data-port accepts this cycle |
| dm_rdata | input | 32 | Load data, valid with the accepting cycle |
| im_valid | output | 1 | Vector-table read request |
| im_addr | output | 32 | Vector-table entry address |
| im_ready | input | 1 | Instruction port accepts this cycle |
| im_rdata | input | 32 | Handler address, valid with the accepting cycle |
| sp_out | output | 32 | Stack pointer after entry or return |
| pc_out | output | 32 | Handler address after entry |
| lr_out | output | 32 | Return code after entry |
| ctx_out | output | 256 | Words restored on return |
| entry_done | output | 1 | One-cycle pulse, entry finished |
| ret_done | output | 1 | One-cycle pulse, return finished |
| ret_err | output | 1 | One-cycle pulse, return code refused |
| handler_mode | output | 1 | 1 in handler mode, 0 in thread mode |

## Verification
Entry is exercised with positive, zero, negative and extreme exception numbers and with stack pointers at several alignments. This separates sign extension and the 64-byte bias in the vector address from the downward frame layout. Every entry is run both with ports that always accept and with ports that stall on differing rhythms, which shows the store order and the parallel vector read are independent of back-pressure and that completion waits for the slower side. The return path is given the supported code, a code with the correct low byte but wrong upper bits, and a code with the correct upper bits but a wrong low byte, and each is checked for memory silence or a full restore. Requests made while busy and a simultaneous entry and return show which request the sequencer takes.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned XLEN        = 32;
  localparam int unsigned FRAME_WORDS = 8;
  localparam int unsigned FRAME_BITS  = FRAME_WORDS * XLEN;
  localparam int unsigned FRAME_BYTES = FRAME_WORDS * (XLEN / 8);
  localparam logic [XLEN-1:0] RET_THREAD_MAIN = 32'hFFFF_FFF9;
  localparam logic [XLEN-1:0] VEC_BIAS        = 32'd64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_PUSH  = 2'd2,
    ST_POP   = 2'd3
  } seq_state_t;

  typedef enum logic {
    DIR_PUSH = 1'b0,
    DIR_POP  = 1'b1
  } stk_dir_t;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  // assert at once, release two edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/exc_stack_engine.sv
module exc_stack_engine
  import exc_seq_pkg::*;
#(
  parameter int unsigned WORDS = FRAME_WORDS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  stk_dir_t               dir,
  input  logic [XLEN-1:0]        base,
  input  logic [WORDS*XLEN-1:0]  wr_words,
  output logic                   dm_valid,
  output logic                   dm_write,
  output logic [XLEN-1:0]        dm_addr,
  output logic [XLEN-1:0]        dm_wdata,
  input  logic                   dm_ready,
  input  logic [XLEN-1:0]        dm_rdata,
  output logic [WORDS*XLEN-1:0]  rd_words,
  output logic                   done
);
  localparam int unsigned CW   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned LAST = WORDS - 1;
  localparam logic [XLEN-1:0] WBYTES = XLEN'(XLEN / 8);

  logic                  active_q, active_n;
  logic                  done_q, done_n;
  stk_dir_t              dir_q, dir_n;
  logic [XLEN-1:0]       base_q, base_n;
  logic [CW-1:0]         beat_q, beat_n;
  logic [WORDS*XLEN-1:0] rd_q, rd_n;
  logic [CW-1:0]         idx;
  logic [XLEN-1:0]       beat_off;
  logic                  fire;
  logic                  ctl_en;
  logic                  rd_en;

  // beat b of a push stores word LAST-b below the base; a pop reads word b above it
  always_comb begin
    idx      = (dir_q == DIR_PUSH) ? (CW'(LAST) - beat_q) : beat_q;
    beat_off = XLEN'(beat_q) * WBYTES;
    dm_addr  = (dir_q == DIR_PUSH) ? (base_q - beat_off - WBYTES) : (base_q + beat_off);
    dm_wdata = wr_words[int'(idx)*XLEN +: XLEN];
    dm_valid = active_q;
    dm_write = (dir_q == DIR_PUSH);
    fire     = active_q & dm_ready;
  end

  always_comb begin
    active_n = active_q;
    done_n   = done_q;
    dir_n    = dir_q;
    base_n   = base_q;
    beat_n   = beat_q;
    rd_n     = rd_q;
    if (start) begin
      active_n = 1'b1;
      done_n   = 1'b0;
      dir_n    = dir;
      base_n   = base;
      beat_n   = '0;
    end else if (fire) begin
      if (dir_q == DIR_POP) begin
        rd_n[int'(idx)*XLEN +: XLEN] = dm_rdata;
      end
      if (beat_q == CW'(LAST)) begin
        active_n = 1'b0;
        done_n   = 1'b1;
      end else begin
        beat_n = beat_q + 1'b1;
      end
    end
  end

  assign ctl_en = start | fire;
  assign rd_en  = fire & (dir_q == DIR_POP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      dir_q    <= DIR_PUSH;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (ctl_en) begin
      active_q <= active_n;
      done_q   <= done_n;
      dir_q    <= dir_n;
      base_q   <= base_n;
      beat_q   <= beat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_n;
    end
  end

  assign rd_words = rd_q;
  assign done     = done_q;
endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
  import exc_seq_pkg::*;
#(
  parameter int unsigned     NUM_W   = 9,
  parameter logic [XLEN-1:0] VT_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  output logic             im_valid,
  output logic [XLEN-1:0]  im_addr,
  input  logic             im_ready,
  input  logic [XLEN-1:0]  im_rdata,
  output logic [XLEN-1:0]  handler,
  output logic             done
);
  localparam int unsigned EXT_W = XLEN - NUM_W;

  logic             active_q, active_n;
  logic             done_q, done_n;
  logic [NUM_W-1:0] num_q;
  logic [XLEN-1:0]  hnd_q;
  logic [XLEN-1:0]  num_ext;
  logic             fire;
  logic             ctl_en;

  // two's-complement number, scaled to words, offset past the sixteen system slots
  always_comb begin
    num_ext  = {{EXT_W{num_q[NUM_W-1]}}, num_q};
    im_addr  = VT_BASE + VEC_BIAS + (num_ext << 2);
    im_valid = active_q;
    fire     = active_q & im_ready;
  end

  always_comb begin
    active_n = active_q;
    done_n   = done_q;
    if (start) begin
      active_n = 1'b1;
      done_n   = 1'b0;
    end else if (fire) begin
      active_n = 1'b0;
      done_n   = 1'b1;
    end
  end

  assign ctl_en = start | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (ctl_en) begin
      active_q <= active_n;
      done_q   <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
    end else if (start) begin
      num_q <= num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hnd_q <= '0;
    end else if (fire) begin
      hnd_q <= im_rdata;
    end
  end

  assign handler = hnd_q;
  assign done    = done_q;
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned NUM_W   = 9,
  parameter logic [31:0] VT_BASE = 32'h0000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  entry_req,
  input  logic [NUM_W-1:0]      entry_num,
  output logic                  entry_rdy,
  input  logic                  insn_done,
  input  logic [FRAME_BITS-1:0] ctx_in,
  input  logic [XLEN-1:0]       sp_in,
  input  logic                  ret_req,
  input  logic [XLEN-1:0]       ret_code,
  output logic                  dm_valid,
  output logic                  dm_write,
  output logic [XLEN-1:0]       dm_addr,
  output logic [XLEN-1:0]       dm_wdata,
  input  logic                  dm_ready,
  input  logic [XLEN-1:0]       dm_rdata,
  output logic                  im_valid,
  output logic [XLEN-1:0]       im_addr,
  input  logic                  im_ready,
  input  logic [XLEN-1:0]       im_rdata,
  output logic [XLEN-1:0]       sp_out,
  output logic [XLEN-1:0]       pc_out,
  output logic [XLEN-1:0]       lr_out,
  output logic [FRAME_BITS-1:0] ctx_out,
  output logic                  entry_done,
  output logic                  ret_done,
  output logic                  ret_err,
  output logic                  handler_mode
);
  localparam logic [XLEN-1:0] FRAME_SZ = XLEN'(FRAME_BYTES);

  logic srst_n;

  seq_state_t            state_q, state_n;
  logic [NUM_W-1:0]      num_q, num_n;
  logic [FRAME_BITS-1:0] ctx_q, ctx_n;
  logic [XLEN-1:0]       base_q, base_n;
  logic [XLEN-1:0]       sp_q, sp_n, pc_q, pc_n, lr_q, lr_n;
  logic [FRAME_BITS-1:0] rest_q, rest_n;
  logic                  mode_q, mode_n;
  logic                  edone_q, edone_n, rdone_q, rdone_n, rerr_q, rerr_n;
  logic                  push_start, pop_start;
  logic                  take_en, out_en;
  logic                  eng_done, vec_done;
  logic [XLEN-1:0]       eng_base;
  logic [FRAME_BITS-1:0] eng_rd;
  logic [XLEN-1:0]       vec_hnd;
  stk_dir_t              eng_dir;

  exc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    state_n    = state_q;
    num_n      = num_q;
    ctx_n      = ctx_q;
    base_n     = base_q;
    sp_n       = sp_q;
    pc_n       = pc_q;
    lr_n       = lr_q;
    rest_n     = rest_q;
    mode_n     = mode_q;
    edone_n    = 1'b0;
    rdone_n    = 1'b0;
    rerr_n     = 1'b0;
    push_start = 1'b0;
    pop_start  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (entry_req) begin
          num_n   = entry_num;
          ctx_n   = ctx_in;
          base_n  = sp_in;
          state_n = ST_DRAIN;
        end else if (ret_req) begin
          if (ret_code == RET_THREAD_MAIN) begin
            pop_start = 1'b1;
            base_n    = sp_in;
            state_n   = ST_POP;
          end else begin
            rerr_n = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (insn_done) begin
          push_start = 1'b1;
          state_n    = ST_PUSH;
        end
      end
      ST_PUSH: begin
        if (eng_done && vec_done) begin
          sp_n    = base_q - FRAME_SZ;
          pc_n    = vec_hnd;
          lr_n    = RET_THREAD_MAIN;
          mode_n  = 1'b1;
          edone_n = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_POP: begin
        if (eng_done) begin
          sp_n    = base_q + FRAME_SZ;
          rest_n  = eng_rd;
          mode_n  = 1'b0;
          rdone_n = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign take_en  = (state_q == ST_IDLE) & (entry_req | pop_start);
  assign out_en   = edone_n | rdone_n;
  assign eng_dir  = pop_start ? DIR_POP : DIR_PUSH;
  assign eng_base = pop_start ? sp_in : base_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      edone_q <= 1'b0;
      rdone_q <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      edone_q <= edone_n;
      rdone_q <= rdone_n;
      rerr_q  <= rerr_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      num_q  <= '0;
      ctx_q  <= '0;
      base_q <= '0;
    end else if (take_en) begin
      num_q  <= num_n;
      ctx_q  <= ctx_n;
      base_q <= base_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sp_q   <= '0;
      pc_q   <= '0;
      lr_q   <= '0;
      rest_q <= '0;
      mode_q <= 1'b0;
    end else if (out_en) begin
      sp_q   <= sp_n;
      pc_q   <= pc_n;
      lr_q   <= lr_n;
      rest_q <= rest_n;
      mode_q <= mode_n;
    end
  end

  exc_stack_engine #(
    .WORDS (FRAME_WORDS)
  ) u_stk (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (push_start | pop_start),
    .dir      (eng_dir),
    .base     (eng_base),
    .wr_words (ctx_q),
    .dm_valid (dm_valid),
    .dm_write (dm_write),
    .dm_addr  (dm_addr),
    .dm_wdata (dm_wdata),
    .dm_ready (dm_ready),
    .dm_rdata (dm_rdata),
    .rd_words (eng_rd),
    .done     (eng_done)
  );

  exc_vec_fetch #(
    .NUM_W   (NUM_W),
    .VT_BASE (VT_BASE)
  ) u_vec (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (push_start),
    .num      (num_q),
    .im_valid (im_valid),
    .im_addr  (im_addr),
    .im_ready (im_ready),
    .im_rdata (im_rdata),
    .handler  (vec_hnd),
    .done     (vec_done)
  );

  assign entry_rdy    = (state_q == ST_IDLE);
  assign sp_out       = sp_q;
  assign pc_out       = pc_q;
  assign lr_out       = lr_q;
  assign ctx_out      = rest_q;
  assign entry_done   = edone_q;
  assign ret_done     = rdone_q;
  assign ret_err      = rerr_q;
  assign handler_mode = mode_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        entry_rdy,
  input logic        dm_valid,
  input logic        dm_write,
  input logic [31:0] dm_addr,
  input logic [31:0] dm_wdata,
  input logic        dm_ready,
  input logic        im_valid,
  input logic [31:0] im_addr,
  input logic        im_ready,
  input logic        entry_done,
  input logic        ret_done,
  input logic        ret_err,
  input logic        handler_mode
);
  assert_dm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid && !dm_ready) |=> (dm_valid && $stable(dm_addr) && $stable(dm_write) && $stable(dm_wdata)));

  assert_im_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (im_valid && !im_ready) |=> (im_valid && $stable(im_addr)));

  assert_busy_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid || im_valid) |-> !entry_rdy);

  assert_word_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid |-> (dm_addr[1:0] == 2'b00));

  assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |-> (!dm_valid && !im_valid && entry_rdy));

  assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_done, ret_done, ret_err}));

  assert_entry_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> (handler_mode && entry_rdy));

  assert_return_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> (!handler_mode && entry_rdy));
endmodule

bind exc_seq exc_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .entry_rdy    (entry_rdy),
  .dm_valid     (dm_valid),
  .dm_write     (dm_write),
  .dm_addr      (dm_addr),
  .dm_wdata     (dm_wdata),
  .dm_ready     (dm_ready),
  .im_valid     (im_valid),
  .im_addr      (im_addr),
  .im_ready     (im_ready),
  .entry_done   (entry_done),
  .ret_done     (ret_done),
  .ret_err      (ret_err),
  .handler_mode (handler_mode)
);

// File: tb/exc_seq_tb.sv
module exc_seq_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          WDOG       = 100000;
  localparam int          N_VEC      = 6;
  localparam logic [31:0] RET_OK     = 32'hFFFF_FFF9;
  localparam logic [31:0] HSALT      = 32'hA500_0000;

  localparam int          VNUM   [N_VEC] = '{2, -11, 0, -16, 239, 5};
  localparam logic [31:0] VSP    [N_VEC] = '{32'h400, 32'h3F0, 32'h800, 32'h624, 32'hFE0, 32'h100};
  localparam bit          VSTALL [N_VEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic         clk, rst_n;
  logic         entry_req, insn_done, ret_req;
  logic [8:0]   entry_num;
  logic [255:0] ctx_in;
  logic [31:0]  sp_in, ret_code;
  logic         entry_rdy, dm_valid, dm_write, dm_ready, im_valid, im_ready;
  logic [31:0]  dm_addr, dm_wdata, dm_rdata, im_addr, im_rdata;
  logic [31:0]  sp_out, pc_out, lr_out;
  logic [255:0] ctx_out;
  logic         entry_done, ret_done, ret_err, handler_mode;

  int n_chk = 0, n_fail = 0;
  bit stall = 1'b0;
  logic [31:0] cyc = '0;
  logic [31:0] dmem [0:1023];
  logic [31:0] wlog_a [0:15], wlog_d [0:15], rlog_a [0:15];
  int wcnt, rcnt, vcnt, first_dm, first_im, first_ins, edone_cnt, rdone_cnt;
  logic [31:0] vaddr_seen;

  exc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_num(entry_num), .entry_rdy(entry_rdy),
    .insn_done(insn_done), .ctx_in(ctx_in), .sp_in(sp_in), .ret_req(ret_req), .ret_code(ret_code),
    .dm_valid(dm_valid), .dm_write(dm_write), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_ready(dm_ready), .dm_rdata(dm_rdata), .im_valid(im_valid), .im_addr(im_addr),
    .im_ready(im_ready), .im_rdata(im_rdata), .sp_out(sp_out), .pc_out(pc_out), .lr_out(lr_out),
    .ctx_out(ctx_out), .entry_done(entry_done), .ret_done(ret_done), .ret_err(ret_err),
    .handler_mode(handler_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign dm_ready = !stall || cyc[0];
  assign im_ready = !stall || (cyc % 3 == 2);
  assign dm_rdata = dmem[dm_addr[11:2]];
  assign im_rdata = HSALT ^ im_addr;

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst_n) begin
      if (dm_valid && first_dm < 0) first_dm = int'(cyc);
      if (im_valid && first_im < 0) first_im = int'(cyc);
      if (insn_done && first_ins < 0) first_ins = int'(cyc);
      if (dm_valid && dm_ready) begin
        if (dm_write) begin
          dmem[dm_addr[11:2]] = dm_wdata;
          if (wcnt < 16) begin wlog_a[wcnt] = dm_addr; wlog_d[wcnt] = dm_wdata; end
          wcnt++;
        end else begin
          if (rcnt < 16) rlog_a[rcnt] = dm_addr;
          rcnt++;
        end
      end
      if (im_valid && im_ready) begin vaddr_seen = im_addr; vcnt++; end
      if (entry_done) edone_cnt++;
      if (ret_done) rdone_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  function automatic logic [255:0] mkctx(input int seed);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = {8'(seed), 8'(k), 16'hC0DE};
    return v;
  endfunction

  task automatic clear_logs();
    wcnt = 0; rcnt = 0; vcnt = 0; first_dm = -1; first_im = -1; first_ins = -1;
    edone_cnt = 0; rdone_cnt = 0;
  endtask

  task automatic wait_entry();
    int n = 0;
    while (entry_done !== 1'b1 && n < 300) begin @(negedge clk); n++; end
    chk("R6 entry_done seen", 256'(entry_done), 256'(1));
  endtask

  task automatic wait_ret();
    int n = 0;
    while (ret_done !== 1'b1 && n < 300) begin @(negedge clk); n++; end
    chk("R7 ret_done seen", 256'(ret_done), 256'(1));
  endtask

  // full entry: request, two cycles of drain, retire, wait
  task automatic do_entry(input int num, input logic [31:0] sp, input logic [255:0] ctx);
    @(negedge clk);
    clear_logs();
    entry_num = 9'(num); sp_in = sp; ctx_in = ctx; entry_req = 1'b1; insn_done = 1'b0;
    @(negedge clk);
    entry_req = 1'b0;
    chk("R1 rdy low after accept", 256'(entry_rdy), 256'(0));
    @(negedge clk);
    @(negedge clk);
    chk("R2 no store before retire", 256'(wcnt), 256'(0));
    insn_done = 1'b1;
    wait_entry();
    insn_done = 1'b0;
  endtask

  task automatic check_entry(input int num, input logic [31:0] sp, input logic [255:0] ctx);
    logic [31:0] va = 32'(64 + 4*num);
    chk("R6 sp_out", 256'(sp_out), 256'(sp - 32'd32));
    chk("R6 pc_out", 256'(pc_out), 256'(HSALT ^ va));
    chk("R6 lr_out", 256'(lr_out), 256'(RET_OK));
    chk("R6 handler_mode", 256'(handler_mode), 256'(1));
    chk("R5 vector addr", 256'(vaddr_seen), 256'(va));
    chk("R5 vector parallel", 256'(first_im), 256'(first_dm));
    chk("R2 first store timing", 256'(first_dm), 256'(first_ins + 1));
    chk("R3 store count", 256'(wcnt), 256'(8));
    for (int b = 0; b < 8; b++) begin
      chk("R3 store addr", 256'(wlog_a[b]), 256'(sp - 32'(4*(b+1))));
      chk("R3 store data", 256'(wlog_d[b]), 256'(ctx[(7-b)*32 +: 32]));
    end
    chk("R1 rdy after entry", 256'(entry_rdy), 256'(1));
  endtask

  task automatic do_return(input logic [31:0] sp, input logic [255:0] ctx);
    logic [31:0] fsp = sp - 32'd32;
    @(negedge clk);
    clear_logs();
    ctx_in = ~ctx; sp_in = fsp; ret_code = RET_OK; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_ret();
    chk("R7 ctx_out", ctx_out, ctx);
    chk("R7 sp_out", 256'(sp_out), 256'(sp));
    chk("R7 thread mode", 256'(handler_mode), 256'(0));
    chk("R7 load count", 256'(rcnt), 256'(8));
    for (int b = 0; b < 8; b++)
      chk("R7 load addr", 256'(rlog_a[b]), 256'(fsp + 32'(4*b)));
  endtask

  task automatic bad_return(input logic [31:0] code, input logic exp_mode, input logic [31:0] exp_sp);
    @(negedge clk);
    clear_logs();
    ret_code = code; sp_in = 32'h300; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    chk("R8 err pulse", 256'(ret_err), 256'(1));
    @(negedge clk);
    chk("R8 err one cycle", 256'(ret_err), 256'(0));
    chk("R8 no memory", 256'(wcnt + rcnt + vcnt), 256'(0));
    chk("R8 mode kept", 256'(handler_mode), 256'(exp_mode));
    chk("R8 sp kept", 256'(sp_out), 256'(exp_sp));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; entry_req = 1'b0; insn_done = 1'b0; ret_req = 1'b0;
    entry_num = '0; ctx_in = '0; sp_in = '0; ret_code = '0;
    clear_logs();
    repeat (3) @(negedge clk);
    chk("R9 rdy in reset", 256'(entry_rdy), 256'(1));
    chk("R9 ports idle", 256'({dm_valid, im_valid, entry_done, ret_done, ret_err, handler_mode}), 256'(0));
    chk("R9 outputs zero", 256'(sp_out | pc_out | lr_out), 256'(0));
    chk("R9 ctx zero", ctx_out, 256'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: entry then return for each vector
    for (int i = 0; i < N_VEC; i++) begin
      logic [255:0] c = mkctx(i + 1);
      stall = VSTALL[i];
      do_entry(VNUM[i], VSP[i], c);
      check_entry(VNUM[i], VSP[i], c);
      do_return(VSP[i], c);
    end
    stall = 1'b0;

    // R8: wrong upper bits, thread mode
    bad_return(32'h0000_00F9, 1'b0, VSP[N_VEC-1]);

    // R8: right upper bits, wrong low byte, inside handler
    begin
      logic [255:0] c = mkctx(40);
      do_entry(1, 32'h700, c);
      bad_return(32'hFFFF_FFF1, 1'b1, 32'h700 - 32'd32);
      do_return(32'h700, c);
    end

    // R1: second request while busy is ignored
    begin
      logic [255:0] c = mkctx(50);
      @(negedge clk);
      clear_logs();
      entry_num = 9'd3; sp_in = 32'h500; ctx_in = c; entry_req = 1'b1; insn_done = 1'b0;
      @(negedge clk);
      entry_num = 9'd7; sp_in = 32'h900; ctx_in = ~c;
      @(negedge clk);
      entry_req = 1'b0; insn_done = 1'b1;
      wait_entry();
      insn_done = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 busy request ignored addr", 256'(vaddr_seen), 256'(32'h4C));
      chk("R1 busy request ignored sp", 256'(sp_out), 256'(32'h4E0));
      chk("R1 single entry", 256'(edone_cnt), 256'(1));
      chk("R1 single frame", 256'(wcnt), 256'(8));
      do_return(32'h500, c);
    end

    // R1: entry wins over simultaneous return
    begin
      logic [255:0] c = mkctx(60);
      @(negedge clk);
      clear_logs();
      entry_num = 9'd4; sp_in = 32'h600; ctx_in = c; entry_req = 1'b1;
      ret_req = 1'b1; ret_code = RET_OK; insn_done = 1'b1;
      @(negedge clk);
      entry_req = 1'b0; ret_req = 1'b0;
      wait_entry();
      insn_done = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 entry wins no return", 256'(rdone_cnt), 256'(0));
      chk("R1 entry wins no loads", 256'(rcnt), 256'(0));
      chk("R1 entry wins mode", 256'(handler_mode), 256'(1));
      do_return(32'h600, c);
    end

    summary();
    $finish;
  end
endmodule